// File: doc/BRIEF.md
# Functional-Unit Issue Steering Scoreboard

This block is the dispatch stage of an in-order, single-issue core with two integer ALUs, two floating-point ALUs and one memory port. Each cycle it sees at most one decoded instruction, given as a class code, up to two source register tags and an optional destination tag. It decides whether the instruction can leave this cycle and, if so, on which unit. The execution datapaths and the register file contents are not part of it.

Two kinds of state drive the decision. Each unit has an occupancy counter that keeps multi-cycle operations (divide, square root, multiply) from sharing that unit. Each register has a countdown that holds its consumers back until the producing operation's latency has passed. Operations that may run on either unit of a pair are steered by a per-pair turn bit. The turn bit alternates between the two units. Operations pinned to one unit of a pair also move the turn bit to the other unit.

An instruction that cannot issue is reported as stalled. The source must keep presenting that instruction until it issues.

Top module: `issue_steer`

## Requirements
- R1: After reset both turn bits point at the low unit of their pair (ALU1, FALU1), every unit is free and every register is ready. With `valid_i` low, `issue_o`, `stall_o` and `unit_o` are all zero.
- R2: A simple integer op (class 0) issues on the ALU that holds the turn, and the turn then moves to the other ALU. Its result latency is 2.
- R3: A control-flow op (class 1) always uses ALU1 with latency 2 and hands the turn to ALU2. An op pinned to ALU2 (classes 2 and 3) hands the turn to ALU1.
- R4: Integer multiply (class 2) runs on ALU2 with latency 5 and holds ALU2 for 2 cycles. Integer divide (class 3) runs on ALU2 with latency 20 and holds ALU2 for 19 cycles.
- R5: If the turn unit of a pair is busy, a flexible op issues on the other unit of that pair, and the turn then points back at the busy unit. If both units are busy, the op stalls and the turn is left unchanged.
- R6: The memory port (bit 4) serves one op per cycle. A load (class 4) has latency 5. A prefetch (class 5) and a store (class 6) have latency 0.
- R7: FP short ops (class 7, latency 3) and FP convert (class 8, latency 5) use FALU1. FP add/multiply/multiply-add (class 9, latency 7) is steered by an FP turn bit that behaves like the integer one.
- R8: FP divide (class 10) uses FALU2 with latency 9 and holds it for 8 cycles. FP square root (class 11) uses FALU2 with latency 15 and holds it for 14 cycles.
- R9: A multi op (class 12) needs both ALUs free. It occupies the turn ALU in its issue cycle and the other ALU in the next cycle, has latency 4, and leaves the turn on the other ALU. `unit_o` shows only the first ALU.
- R10: Classes 13 to 15 claim all five units for one cycle with latency 1 (`unit_o` = 5'b11111) and leave both turn bits unchanged.
- R11: Issuing an op with latency L that writes register d blocks any op that reads d (with the matching `src_en_i` bit set) until L cycles after the producer issued. Ops with latency 0 or 1 block nothing.
- R12: An op whose destination register still has a pending result stalls until that result is ready.
- R13: `unit_o` is one-hot except as R9 and R10 state, with bit 0 = ALU1, bit 1 = ALU2, bit 2 = FALU1, bit 3 = FALU2 and bit 4 = memory. It is zero whenever `issue_o` is low. `stall_o` is high exactly when `valid_i` is high and `issue_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is presented |
| class_i | input | 4 | Operation class code |
| src_en_i | input | 2 | Bit 0 enables source A, bit 1 enables source B |
| src_a_i | input | TAG_W | Source A register tag |
| src_b_i | input | TAG_W | Source B register tag |
| dst_we_i | input | 1 | The instruction writes a destination register |
| dst_i | input | TAG_W | Destination register tag |
| issue_o | output | 1 | The instruction issues this cycle |
| stall_o | output | 1 | The instruction is held this cycle |
| unit_o | output | 5 | Selected unit(s), encoded as in R13 |

## Verification
The assertions assume that `class_i`, the tags and the enables are known values whenever `valid_i` is high, and that the tags stay below the register count. The hazard property also assumes that a stalled instruction is presented again unchanged in the next cycle. The bench respects all of this. It draws tags only from a small low range, so dependences occur often. It keeps a stalled instruction on the inputs until it issues. It mixes long-occupancy classes with flexible ones, so that the busy-unit fallback, the dependence stalls and the pinned-unit turn hand-offs all show up in the random traffic.

// File: rtl/issue_steer_pkg.sv
package issue_steer_pkg;
  localparam int NUM_UNITS = 5;
  localparam int LAT_W     = 5;
  localparam int OCC_W     = 5;

  localparam int U_ALU1  = 0;
  localparam int U_ALU2  = 1;
  localparam int U_FALU1 = 2;
  localparam int U_FALU2 = 3;
  localparam int U_MEM   = 4;

  localparam logic [NUM_UNITS-1:0] M_ALU1  = NUM_UNITS'(1) << U_ALU1;
  localparam logic [NUM_UNITS-1:0] M_ALU2  = NUM_UNITS'(1) << U_ALU2;
  localparam logic [NUM_UNITS-1:0] M_FALU1 = NUM_UNITS'(1) << U_FALU1;
  localparam logic [NUM_UNITS-1:0] M_FALU2 = NUM_UNITS'(1) << U_FALU2;
  localparam logic [NUM_UNITS-1:0] M_MEM   = NUM_UNITS'(1) << U_MEM;
  localparam logic [NUM_UNITS-1:0] M_ALL   = {NUM_UNITS{1'b1}};

  // occupancy values are extra cycles beyond the issue cycle
  localparam int LAT_INT = 2,  LAT_CTRL = 2;
  localparam int LAT_IMUL = 5, OCC_IMUL = 1;
  localparam int LAT_IDIV = 20, OCC_IDIV = 18;
  localparam int LAT_LOAD = 5, LAT_PREF = 0, LAT_STORE = 0;
  localparam int LAT_FSHORT = 3, LAT_FCVT = 5, LAT_FARITH = 7;
  localparam int LAT_FDIV = 9, OCC_FDIV = 7;
  localparam int LAT_FSQRT = 15, OCC_FSQRT = 13;
  localparam int LAT_MULTI = 4, LAT_OTHER = 1;

  typedef enum logic [3:0] {
    CL_INT    = 4'd0,
    CL_CTRL   = 4'd1,
    CL_IMUL   = 4'd2,
    CL_IDIV   = 4'd3,
    CL_LOAD   = 4'd4,
    CL_PREF   = 4'd5,
    CL_STORE  = 4'd6,
    CL_FSHORT = 4'd7,
    CL_FCVT   = 4'd8,
    CL_FARITH = 4'd9,
    CL_FDIV   = 4'd10,
    CL_FSQRT  = 4'd11,
    CL_MULTI  = 4'd12
  } op_class_e;

  typedef struct packed {
    logic [NUM_UNITS-1:0] fix;
    logic                 flex_int;
    logic                 flex_fp;
    logic                 multi;
    logic [LAT_W-1:0]     lat;
    logic [OCC_W-1:0]     occ;
  } op_info_t;

  function automatic op_info_t decode_op(logic [3:0] cls);
    op_info_t r;
    r = '0;
    case (cls)
      CL_INT:    begin r.flex_int = 1'b1; r.lat = LAT_W'(LAT_INT); end
      CL_CTRL:   begin r.fix = M_ALU1; r.lat = LAT_W'(LAT_CTRL); end
      CL_IMUL:   begin r.fix = M_ALU2; r.lat = LAT_W'(LAT_IMUL); r.occ = OCC_W'(OCC_IMUL); end
      CL_IDIV:   begin r.fix = M_ALU2; r.lat = LAT_W'(LAT_IDIV); r.occ = OCC_W'(OCC_IDIV); end
      CL_LOAD:   begin r.fix = M_MEM;  r.lat = LAT_W'(LAT_LOAD); end
      CL_PREF:   begin r.fix = M_MEM;  r.lat = LAT_W'(LAT_PREF); end
      CL_STORE:  begin r.fix = M_MEM;  r.lat = LAT_W'(LAT_STORE); end
      CL_FSHORT: begin r.fix = M_FALU1; r.lat = LAT_W'(LAT_FSHORT); end
      CL_FCVT:   begin r.fix = M_FALU1; r.lat = LAT_W'(LAT_FCVT); end
      CL_FARITH: begin r.flex_fp = 1'b1; r.lat = LAT_W'(LAT_FARITH); end
      CL_FDIV:   begin r.fix = M_FALU2; r.lat = LAT_W'(LAT_FDIV); r.occ = OCC_W'(OCC_FDIV); end
      CL_FSQRT:  begin r.fix = M_FALU2; r.lat = LAT_W'(LAT_FSQRT); r.occ = OCC_W'(OCC_FSQRT); end
      CL_MULTI:  begin r.multi = 1'b1; r.lat = LAT_W'(LAT_MULTI); end
      default:   begin r.fix = M_ALL; r.lat = LAT_W'(LAT_OTHER); end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pair_steer.sv
module pair_steer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flex_i,
  input  logic       both_i,
  input  logic       fix_lo_i,
  input  logic       fix_hi_i,
  input  logic       free_lo_i,
  input  logic       free_hi_i,
  input  logic       commit_i,
  output logic       ok_o,
  output logic [1:0] claim_o,
  output logic [1:0] lead_o
);
  logic turn_q;  // 1: high unit holds the turn
  logic pref_free, alt_free, take_hi, moves_turn;

  always_comb begin
    pref_free = turn_q ? free_hi_i : free_lo_i;
    alt_free  = turn_q ? free_lo_i : free_hi_i;
    take_hi   = turn_q;
    ok_o      = 1'b1;
    claim_o   = 2'b00;
    lead_o    = 2'b00;
    if (both_i) begin
      ok_o    = free_lo_i & free_hi_i;
      claim_o = 2'b11;
      lead_o  = turn_q ? 2'b10 : 2'b01;
    end else if (flex_i) begin
      take_hi = pref_free ? turn_q : ~turn_q;
      ok_o    = pref_free | alt_free;
      claim_o = take_hi ? 2'b10 : 2'b01;
      lead_o  = claim_o;
    end else begin
      take_hi = fix_hi_i;
      claim_o = {fix_hi_i, fix_lo_i};
      lead_o  = claim_o;
      ok_o    = (~fix_lo_i | free_lo_i) & (~fix_hi_i | free_hi_i);
    end
  end

  assign moves_turn = both_i | flex_i | (fix_lo_i ^ fix_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      turn_q <= 1'b0;
    else if (commit_i && moves_turn) turn_q <= ~take_hi;
  end
endmodule

// File: rtl/unit_busy.sv
module unit_busy #(
  parameter int N = 5,
  parameter int W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        claim_i,
  input  logic [N-1:0][W-1:0] occ_i,
  output logic [N-1:0]        free_o
);
  for (genvar g = 0; g < N; g++) begin : g_unit
    logic [W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (claim_i[g])    cnt_q <= occ_i[g];
      else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
    end
    assign free_o[g] = (cnt_q == '0);
  end
endmodule

// File: rtl/ready_board.sv
module ready_board #(
  parameter int NREG  = 32,
  parameter int TAG_W = 5,
  parameter int W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] src_a_i,
  input  logic [TAG_W-1:0] src_b_i,
  input  logic [TAG_W-1:0] dst_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wr_val_i,
  output logic             src_a_pend_o,
  output logic             src_b_pend_o,
  output logic             dst_pend_o
);
  logic [NREG-1:0][W-1:0] cnt_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                cnt_q[g] <= '0;
      else if (wr_i && dst_i == TAG_W'(g))        cnt_q[g] <= wr_val_i;
      else if (cnt_q[g] != '0)                    cnt_q[g] <= cnt_q[g] - W'(1);
    end
  end

  assign src_a_pend_o = (cnt_q[src_a_i] != '0);
  assign src_b_pend_o = (cnt_q[src_b_i] != '0);
  assign dst_pend_o   = (cnt_q[dst_i] != '0);
endmodule

// File: rtl/issue_steer.sv
module issue_steer
  import issue_steer_pkg::*;
#(
  parameter  int NREG  = 32,
  localparam int TAG_W = $clog2(NREG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [3:0]           class_i,
  input  logic [1:0]           src_en_i,
  input  logic [TAG_W-1:0]     src_a_i,
  input  logic [TAG_W-1:0]     src_b_i,
  input  logic                 dst_we_i,
  input  logic [TAG_W-1:0]     dst_i,
  output logic                 issue_o,
  output logic                 stall_o,
  output logic [NUM_UNITS-1:0] unit_o
);
  op_info_t info;
  logic [NUM_UNITS-1:0] free, claim, claim_iss;
  logic [NUM_UNITS-1:0][OCC_W-1:0] occ;
  logic [1:0] claim_int, lead_int, claim_fp, lead_fp, trail_int;
  logic ok_int, ok_fp, ok_mem, hazard;
  logic pend_a, pend_b, pend_d;
  logic [LAT_W-1:0] wr_val;

  assign info = decode_op(class_i);

  pair_steer int_pair_i (
    .clk_i, .rst_ni,
    .flex_i(info.flex_int), .both_i(info.multi),
    .fix_lo_i(info.fix[U_ALU1]), .fix_hi_i(info.fix[U_ALU2]),
    .free_lo_i(free[U_ALU1]), .free_hi_i(free[U_ALU2]),
    .commit_i(issue_o),
    .ok_o(ok_int), .claim_o(claim_int), .lead_o(lead_int)
  );

  pair_steer fp_pair_i (
    .clk_i, .rst_ni,
    .flex_i(info.flex_fp), .both_i(1'b0),
    .fix_lo_i(info.fix[U_FALU1]), .fix_hi_i(info.fix[U_FALU2]),
    .free_lo_i(free[U_FALU1]), .free_hi_i(free[U_FALU2]),
    .commit_i(issue_o),
    .ok_o(ok_fp), .claim_o(claim_fp), .lead_o(lead_fp)
  );

  assign ok_mem = ~info.fix[U_MEM] | free[U_MEM];
  assign claim  = {info.fix[U_MEM], claim_fp, claim_int};

  ready_board #(.NREG(NREG), .TAG_W(TAG_W), .W(LAT_W)) board_i (
    .clk_i, .rst_ni,
    .src_a_i, .src_b_i, .dst_i,
    .wr_i(issue_o & dst_we_i), .wr_val_i(wr_val),
    .src_a_pend_o(pend_a), .src_b_pend_o(pend_b), .dst_pend_o(pend_d)
  );

  // consumers wait lat cycles: counter holds lat-1
  assign wr_val = (info.lat == '0) ? '0 : info.lat - LAT_W'(1);

  assign hazard  = (src_en_i[0] & pend_a) | (src_en_i[1] & pend_b) | (dst_we_i & pend_d);
  assign issue_o = valid_i & ok_int & ok_fp & ok_mem & ~hazard;
  assign stall_o = valid_i & ~issue_o;

  assign claim_iss = issue_o ? claim : '0;
  assign unit_o    = issue_o ? {info.fix[U_MEM], lead_fp, lead_int} : '0;
  assign trail_int = claim_int & ~lead_int;

  always_comb begin
    for (int g = 0; g < NUM_UNITS; g++) occ[g] = info.occ;
    for (int g = 0; g < 2; g++) if (trail_int[g]) occ[g] = OCC_W'(1);
  end

  unit_busy #(.N(NUM_UNITS), .W(OCC_W)) busy_i (
    .clk_i, .rst_ni,
    .claim_i(claim_iss), .occ_i(occ), .free_o(free)
  );
endmodule

// File: rtl/issue_steer_chk.sv
module issue_steer_chk
  import issue_steer_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [3:0]           class_i,
  input logic [1:0]           src_en_i,
  input logic [TAG_W-1:0]     src_a_i,
  input logic                 dst_we_i,
  input logic [TAG_W-1:0]     dst_i,
  input logic                 issue_o,
  input logic                 stall_o,
  input logic [NUM_UNITS-1:0] unit_o
);
  assert_ctrl_alu1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && class_i == CL_CTRL |-> unit_o == M_ALU1);

  assert_imul_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && class_i == CL_IMUL |=> !(issue_o && unit_o[U_ALU2]));

  assert_flex_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && class_i == CL_INT |-> $countones(unit_o) == 1 && (unit_o & ~(M_ALU1 | M_ALU2)) == '0);

  assert_fdiv_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && class_i == CL_FDIV |=> !(issue_o && unit_o[U_FALU2]));

  assert_other_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && class_i >= 4'd13 |-> unit_o == M_ALL);

  assert_raw_block_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && dst_we_i && class_i == CL_INT |=> !(issue_o && src_en_i[0] && src_a_i == $past(dst_i)));

  assert_idle_unit_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_o |-> unit_o == '0);

  assert_stall_valid_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> valid_i && !issue_o);
endmodule

bind issue_steer issue_steer_chk #(.TAG_W(TAG_W)) chk_i (.*);

// File: tb/issue_steer_tb_top.sv
module issue_steer_tb_top;
  localparam int NREG  = 32;
  localparam int TAG_W = $clog2(NREG);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, dst_we_i = 1'b0;
  logic [3:0] class_i = '0;
  logic [1:0] src_en_i = '0;
  logic [TAG_W-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic issue_o, stall_o;
  logic [4:0] unit_o;

  int checks = 0, errors = 0, cyc = 0;

  issue_steer #(.NREG(NREG)) dut_i (.*);

  always #10 clk_i = ~clk_i;

  // behavioural reference state
  int busy[5];
  int rdy[NREG];
  int t_int, t_fp;           // 0: low unit has turn
  bit e_iss;
  bit [4:0] e_unit;
  int e_kind, e_u, e_lat, e_occ;
  bit [4:0] e_mask;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 5; i++) busy[i] = 0;
    for (int i = 0; i < NREG; i++) rdy[i] = 0;
    t_int = 0; t_fp = 0;
  endtask

  task automatic model_eval();
    bit ok, haz;
    e_kind = 2; e_mask = 0; e_lat = 0; e_occ = 0; e_u = -1;
    case (class_i)
      0:  begin e_kind = 0; e_lat = 2; end
      1:  begin e_mask = 5'b00001; e_lat = 2; end
      2:  begin e_mask = 5'b00010; e_lat = 5; e_occ = 1; end
      3:  begin e_mask = 5'b00010; e_lat = 20; e_occ = 18; end
      4:  begin e_mask = 5'b10000; e_lat = 5; end
      5, 6: begin e_mask = 5'b10000; e_lat = 0; end
      7:  begin e_mask = 5'b00100; e_lat = 3; end
      8:  begin e_mask = 5'b00100; e_lat = 5; end
      9:  begin e_kind = 1; e_lat = 7; end
      10: begin e_mask = 5'b01000; e_lat = 9; e_occ = 7; end
      11: begin e_mask = 5'b01000; e_lat = 15; e_occ = 13; end
      12: begin e_kind = 3; e_lat = 4; end
      default: begin e_mask = 5'b11111; e_lat = 1; end
    endcase
    haz = (src_en_i[0] && rdy[src_a_i] > 0) || (src_en_i[1] && rdy[src_b_i] > 0) ||
          (dst_we_i && rdy[dst_i] > 0);
    ok = 1'b1;
    if (e_kind == 0 || e_kind == 1) begin
      int base = (e_kind == 0) ? 0 : 2;
      int p = base + ((e_kind == 0) ? t_int : t_fp);
      int q = (p == base) ? base + 1 : base;
      if (busy[p] == 0) e_u = p;
      else if (busy[q] == 0) e_u = q;
      ok = (e_u >= 0);
      e_unit = (e_u >= 0) ? 5'(1 << e_u) : 5'b0;
    end else if (e_kind == 3) begin
      ok = (busy[0] == 0 && busy[1] == 0);
      e_u = t_int;
      e_unit = 5'(1 << t_int);
    end else begin
      for (int i = 0; i < 5; i++) if (e_mask[i] && busy[i] != 0) ok = 1'b0;
      e_unit = e_mask;
    end
    e_iss = valid_i && ok && !haz;
    if (!e_iss) e_unit = 5'b0;
  endtask

  task automatic model_tick();
    for (int i = 0; i < 5; i++) if (busy[i] > 0) busy[i]--;
    for (int i = 0; i < NREG; i++) if (rdy[i] > 0) rdy[i]--;
    if (!e_iss) return;
    if (e_kind == 0) t_int = (e_u == 0) ? 1 : 0;
    else if (e_kind == 1) t_fp = (e_u == 2) ? 1 : 0;
    else if (e_kind == 3) begin busy[1 - e_u] = 1; t_int = 1 - e_u; end
    else begin
      for (int i = 0; i < 5; i++) if (e_mask[i]) busy[i] = e_occ;
      if (e_mask == 5'b00001) t_int = 1;
      if (e_mask == 5'b00010) t_int = 0;
      if (e_mask == 5'b00100) t_fp = 1;
      if (e_mask == 5'b01000) t_fp = 0;
    end
    if (dst_we_i) rdy[dst_i] = (e_lat > 0) ? e_lat - 1 : 0;
  endtask

  // one cycle: drive at falling edge, compare, advance model
  task automatic cyc_step(input bit v, input int c, input bit [1:0] se, input int a, input int b,
                          input bit we, input int d, input string req);
    @(negedge clk_i);
    valid_i = v; class_i = 4'(c); src_en_i = se;
    src_a_i = TAG_W'(a); src_b_i = TAG_W'(b); dst_we_i = we; dst_i = TAG_W'(d);
    #2;
    model_eval();
    chk(issue_o == e_iss, req, issue_o, e_iss);
    chk(unit_o == e_unit, req, unit_o, e_unit);
    chk(stall_o == (v && !e_iss), req, stall_o, v && !e_iss);
    model_tick();
  endtask

  // hold an instruction until it issues; returns cycles spent stalled
  task automatic op(input int c, input bit [1:0] se, input int a, input int b,
                    input bit we, input int d, input string req, output int waited);
    waited = 0;
    cyc_step(1'b1, c, se, a, b, we, d, req);
    while (!e_iss && waited < 40) begin
      waited++;
      cyc_step(1'b1, c, se, a, b, we, d, req);
    end
  endtask

  initial begin
    int w;
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 idle after reset
    cyc_step(1'b0, 0, 2'b00, 0, 0, 1'b0, 0, "R1");
    chk(issue_o == 0 && unit_o == 0 && stall_o == 0, "R1", unit_o, 0);
    op(0, 2'b00, 0, 0, 1, 1, "R1", w);
    chk(unit_o == 5'b00001, "R1", unit_o, 1);
    // R2 ping-pong
    op(0, 2'b00, 0, 0, 1, 2, "R2", w);
    chk(unit_o == 5'b00010, "R2", unit_o, 2);
    op(0, 2'b00, 0, 0, 1, 3, "R2", w);
    chk(unit_o == 5'b00001, "R2", unit_o, 1);
    // R11 dependence on a latency-2 result: one stalled cycle
    op(0, 2'b00, 0, 0, 1, 4, "R11", w);
    op(0, 2'b01, 4, 0, 1, 7, "R11", w);
    chk(w == 1, "R11", w, 1);
    // R3 pinned ops hand over the turn
    op(1, 2'b00, 0, 0, 0, 0, "R3", w);
    op(0, 2'b00, 0, 0, 0, 0, "R3", w);
    chk(unit_o == 5'b00010, "R3", unit_o, 2);
    op(2, 2'b00, 0, 0, 1, 8, "R3", w);
    op(0, 2'b00, 0, 0, 0, 0, "R3", w);
    chk(unit_o == 5'b00001, "R3", unit_o, 1);
    // R4 divide holds ALU2 for 19 cycles; R5 flex ops fall back to ALU1
    repeat (4) @(negedge clk_i);
    model_tick_idle();
    op(3, 2'b00, 0, 0, 1, 9, "R4", w);
    op(0, 2'b00, 0, 0, 0, 0, "R5", w);
    chk(unit_o == 5'b00001, "R5", unit_o, 1);
    op(0, 2'b00, 0, 0, 0, 0, "R5", w);
    chk(unit_o == 5'b00001, "R5", unit_o, 1);
    op(2, 2'b00, 0, 0, 0, 0, "R4", w);
    chk(w == 16, "R4", w, 16);
    // R12 destination still pending from the divide's neighbour
    op(4, 2'b00, 0, 0, 1, 10, "R6", w);
    op(0, 2'b00, 0, 0, 1, 10, "R12", w);
    chk(w == 4, "R12", w, 4);
    // R6 memory port back to back, zero latency stores/prefetches
    op(6, 2'b00, 0, 0, 0, 0, "R6", w);
    op(5, 2'b00, 0, 0, 1, 11, "R6", w);
    op(0, 2'b01, 11, 0, 0, 0, "R6", w);
    chk(w == 0, "R6", w, 0);
    // R7 FP turn bit
    op(7, 2'b00, 0, 0, 1, 12, "R7", w);
    op(9, 2'b00, 0, 0, 0, 0, "R7", w);
    chk(unit_o == 5'b01000, "R7", unit_o, 8);
    op(9, 2'b00, 0, 0, 0, 0, "R7", w);
    chk(unit_o == 5'b00100, "R7", unit_o, 4);
    // R8 square root then divide on FALU2
    op(11, 2'b00, 0, 0, 0, 0, "R8", w);
    op(10, 2'b00, 0, 0, 0, 0, "R8", w);
    chk(w == 13, "R8", w, 13);
    op(9, 2'b00, 0, 0, 0, 0, "R5", w);
    chk(unit_o == 5'b00100, "R5", unit_o, 4);
    // R9 multi then flex int uses the first ALU again
    repeat (10) cyc_step(1'b0, 0, 2'b00, 0, 0, 1'b0, 0, "R13");
    op(12, 2'b00, 0, 0, 1, 13, "R9", w);
    chk($countones(unit_o) == 1, "R9", unit_o, 1);
    op(0, 2'b01, 13, 0, 0, 0, "R9", w);
    chk(w == 3, "R9", w, 3);
    // R10 unknown class
    op(15, 2'b00, 0, 0, 0, 0, "R10", w);
    chk(unit_o == 5'b11111, "R10", unit_o, 31);
    op(0, 2'b00, 0, 0, 0, 0, "R10", w);
    chk(w == 0, "R10", w, 0);
    // random traffic compared on every clock
    begin
      bit v = 0, we = 0; int c = 0, a = 0, b = 0, d = 0; bit [1:0] se = 0;
      for (int n = 0; n < 4000; n++) begin
        if (!(v && !e_iss)) begin
          v = ($urandom_range(0, 9) < 8);
          c = $urandom_range(0, 15); se = 2'($urandom_range(0, 3));
          a = $urandom_range(0, 7); b = $urandom_range(0, 7);
          d = $urandom_range(0, 7); we = (c != 5 && c != 6) && $urandom_range(0, 3) != 0;
        end
        cyc_step(v, c, se, a, b, we, d, "R13");
      end
    end
    summary();
  end

  // idle cycles already elapsed without driving: keep model aligned
  task automatic model_tick_idle();
    e_iss = 1'b0;
    for (int k = 0; k < 4; k++) model_tick();
  endtask
endmodule